// File: doc/BRIEF.md
# Fractional Reference Clock Enable Bank

This block derives four independent clock-enable streams from a single fast source clock. Each stream runs at an average rate of the source rate multiplied by 18 and divided by a per-channel fraction value. The fraction can be set between 18 and 35, so each stream runs at somewhere between just over half the source rate and the full source rate. Downstream logic uses a stream by qualifying its registers with the one-cycle enable pulses, so only one real clock is needed.

All controls sit in one 32-bit control word, with one byte per channel. The low six bits of byte n hold the fraction for channel n, and the top bit of that byte stops channel n while it is 1. Software reaches the word through a two-bit write address: a plain write replaces the whole word, a set write ORs ones into it, and a clear write removes the bits that are written as one. The current word is always readable. Because of the set and clear writes, one channel can be started or stopped without a read-modify-write of the shared word.

A fraction outside the legal range is clamped in hardware before the divider uses it, but the stored bits are kept unchanged. A stopped channel drops its enable output and holds its phase at zero, so it restarts the same way every time.

Top module: `refclk_bank`

## Requirements
- R1: After synchronous reset the control word reads 0x92929292 (every channel stopped, every fraction 18), and all four enable outputs stay low.
- R2: A write with wr_addr = 0 replaces the whole control word with wr_data, and rd_data shows the new word from the cycle after the write edge.
- R3: A write with wr_addr = 1 ORs wr_data into the control word.
- R4: A write with wr_addr = 2 clears each control-word bit whose wr_data bit is 1 and leaves the other bits as they were.
- R5: A write with wr_addr = 3, or any cycle with wr_en low, leaves the control word unchanged.
- R6: Channel n takes its fraction F from bits 8n+5..8n and its stop bit from bit 8n+7. Once it is running, it emits exactly floor(18*W/F) enable pulses in its first W cycles, counting from the second clock edge after the write that started it. Each pulse is one cycle wide.
- R7: When the stop bit of a channel is 1 at a clock edge, the enable output of that channel is low after the next edge. A stopped channel restarts with zero phase, so R6 holds again after every restart.
- R8: A fraction below 18 acts as 18, which gives a pulse on every cycle, and a fraction above 35 acts as 35. The control word still returns the raw stored bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 2 | Write kind: 0 replace, 1 set bits, 2 clear bits, 3 none |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| ch_en | output | 4 | Per-channel enable pulses |

## Verification
A corrupted control word shows at once on rd_data. A wrong register update therefore appears on the cycle after the write edge. A bad phase accumulator shows only as a pulse count that is off over a window. For that reason, every running channel is counted over windows of up to a hundred cycles, and the counts are compared against floor(18*W/F), which catches a wrong step, a wrong clamp or a missing restart within one fraction period. A stop that takes effect late shows up as a pulse in the cycle after the stop has been sampled.

// File: rtl/refclk_pkg.sv
// Shared constants and types for the fractional reference clock bank.
// Assumes a byte-per-channel layout with the stop bit at the top of the byte.
package refclk_pkg;

    localparam int LANE_W   = 8;    // bits per channel in the control word
    localparam int FRAC_W   = 6;    // width of the fraction field
    localparam int STEP     = 18;   // accumulator increment per source cycle
    localparam int FRAC_LO  = 18;   // smallest usable fraction
    localparam int FRAC_HI  = 35;   // largest usable fraction
    localparam int STOP_BIT = LANE_W - 1;

    // Kind of write selected by the write address
    typedef enum logic [1:0] {
        OP_REPLACE = 2'd0,
        OP_SET     = 2'd1,
        OP_CLEAR   = 2'd2,
        OP_NONE    = 2'd3
    } reg_op_e;

    // Reset lane: stopped, fraction at the low limit
    localparam logic [LANE_W-1:0] LANE_RESET =
        LANE_W'((1 << STOP_BIT) | FRAC_LO);

endpackage

// File: rtl/refclk_ctrl_reg.sv
// Control word with replace, set-bits and clear-bits writes.
// Assumes a single-cycle write strobe synchronous to clk.
module refclk_ctrl_reg
    import refclk_pkg::*;
#(
    parameter int                WORD_W    = 32,
    parameter logic [WORD_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] word
);

    // Apply the selected write kind to the stored word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= RESET_VAL;
        end else if (wr_en) begin
            case (reg_op_e'(wr_addr))
                OP_REPLACE: word <= wr_data;
                OP_SET:     word <= word | wr_data;
                OP_CLEAR:   word <= word & ~wr_data;
                default:    word <= word;
            endcase
        end
    end

endmodule

// File: rtl/refclk_frac_clamp.sv
// Limits a raw fraction field to the usable range [LO, HI].
// Purely combinational; assumes LO <= HI and both fit in W bits.
module refclk_frac_clamp #(
    parameter int W  = 6,
    parameter int LO = 18,
    parameter int HI = 35
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] eff
);

    // Saturate to the nearer limit
    always_comb begin
        if (raw < W'(LO))      eff = W'(LO);
        else if (raw > W'(HI)) eff = W'(HI);
        else                   eff = raw;
    end

endmodule

// File: rtl/refclk_channel.sv
// One fractional divider: adds STEP every cycle and emits a pulse whenever
// the sum reaches the fraction, subtracting it. Assumes fraction >= STEP so
// at most one pulse per cycle. A stop holds the phase at zero.
module refclk_channel
    import refclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop,
    input  logic [FRAC_W-1:0] frac_raw,
    output logic              pulse
);

    localparam int SUM_W = FRAC_W + 1;

    logic [FRAC_W-1:0] frac_eff;
    logic [SUM_W-1:0]  acc;
    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  limit;

    refclk_frac_clamp #(
        .W  (FRAC_W),
        .LO (FRAC_LO),
        .HI (FRAC_HI)
    ) u_clamp (
        .raw (frac_raw),
        .eff (frac_eff)
    );

    // Candidate phase after this cycle's increment
    always_comb begin
        limit = {1'b0, frac_eff};
        sum   = acc + SUM_W'(STEP);
    end

    // Advance the phase and register the enable pulse
    always_ff @(posedge clk) begin
        if (!rst_n || stop) begin
            acc   <= '0;
            pulse <= 1'b0;
        end else if (sum >= limit) begin
            acc   <= sum - limit;
            pulse <= 1'b1;
        end else begin
            acc   <= sum;
            pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/refclk_bank.sv
// Bank of N_CH fractional clock-enable channels sharing one control word,
// one byte per channel. Assumes all logic runs on the source clock.
module refclk_bank
    import refclk_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_addr,
    input  logic [N_CH*LANE_W-1:0]   wr_data,
    output logic [N_CH*LANE_W-1:0]   rd_data,
    output logic [N_CH-1:0]          ch_en
);

    localparam int WORD_W = N_CH * LANE_W;
    localparam logic [WORD_W-1:0] WORD_RESET = {N_CH{LANE_RESET}};

    logic [WORD_W-1:0] word;

    refclk_ctrl_reg #(
        .WORD_W    (WORD_W),
        .RESET_VAL (WORD_RESET)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .word    (word)
    );

    assign rd_data = word;

    // One divider per byte lane
    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        refclk_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .stop     (word[n*LANE_W + STOP_BIT]),
            .frac_raw (word[n*LANE_W +: FRAC_W]),
            .pulse    (ch_en[n])
        );
    end

endmodule

// File: rtl/refclk_bank_chk.sv
// Assertion checker for refclk_bank, bound to every instance.
module refclk_bank_chk
    import refclk_pkg::*;
#(
    parameter int N_CH = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [1:0]             wr_addr,
    input logic [N_CH*LANE_W-1:0] wr_data,
    input logic [N_CH*LANE_W-1:0] rd_data,
    input logic [N_CH-1:0]        ch_en
);

    AST_REPLACE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> rd_data == $past(wr_data)); // R2

    AST_SET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> rd_data == ($past(rd_data) | $past(wr_data))); // R3

    AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2) |=> rd_data == ($past(rd_data) & ~$past(wr_data))); // R4

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr == 2'd3) |=> $stable(rd_data)); // R5

    for (genvar n = 0; n < N_CH; n++) begin : g_lane
        AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[n*LANE_W + STOP_BIT] |=> !ch_en[n]); // R7

        AST_LOW_FRAC_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_data[n*LANE_W + STOP_BIT] && rd_data[n*LANE_W +: FRAC_W] <= FRAC_W'(FRAC_LO))
            |=> ch_en[n]); // R8
    end

endmodule

bind refclk_bank refclk_bank_chk #(.N_CH(N_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .ch_en   (ch_en)
);

// File: tb/sim_refclk_bank.sv
module sim_refclk_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  ch_en;

    int n_checks = 0;
    int n_fail   = 0;
    int cnt [4];

    always #5 clk = ~clk;

    refclk_bank u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .ch_en   (ch_en)
    );

    // Vector table: control word to write and counting window in cycles
    localparam int NV = 5;
    localparam logic [31:0] VEC_WORD [NV] = '{
        32'h12121212, 32'h23222120, 32'h9A1B2312, 32'h05233F14, 32'h1D1C8115
    };
    localparam int VEC_WIN [NV] = '{40, 70, 100, 77, 90};

    function automatic int eff_frac(input logic [5:0] f);
        if (f < 6'd18) return 18;
        if (f > 6'd35) return 35;
        return int'(f);
    endfunction

    function automatic int exp_pulses(input logic [7:0] lane, input int w);
        if (lane[7]) return 0;
        return (18 * w) / eff_frac(lane[5:0]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic count(input int w);
        for (int c = 0; c < 4; c++) cnt[c] = 0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) cnt[c] += int'(ch_en[c]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset word and silent outputs
        chk("R1 reset word", rd_data, 32'h92929292);
        count(20);
        for (int c = 0; c < 4; c++) chk("R1 no pulses after reset", cnt[c], 0);

        // Vector walk: stop all, load word, count pulses (R2, R6, R7 restart, R8)
        for (int v = 0; v < NV; v++) begin
            wr(2'd1, 32'h80808080);
            wr(2'd0, VEC_WORD[v]);
            chk("R2 replace readback / R8 raw bits kept", rd_data, VEC_WORD[v]);
            count(VEC_WIN[v]);
            for (int c = 0; c < 4; c++)
                chk("R6 pulse count", cnt[c],
                    exp_pulses(VEC_WORD[v][c*8 +: 8], VEC_WIN[v]));
        end

        // Back to a known word
        wr(2'd0, 32'h92929292);
        chk("R2 replace", rd_data, 32'h92929292);

        // R3: set bits
        wr(2'd1, 32'h00000040);
        chk("R3 set write", rd_data, 32'h929292D2);

        // R4: clear bits
        wr(2'd2, 32'h80000080);
        chk("R4 clear write", rd_data, 32'h12929252);

        // R5: address 3 and idle strobe leave the word
        wr(2'd3, 32'hFFFFFFFF);
        chk("R5 addr 3 ignored", rd_data, 32'h12929252);
        wr_addr = 2'd0;
        wr_data = 32'h0;
        @(negedge clk);
        chk("R5 wr_en low ignored", rd_data, 32'h12929252);

        // R8: ch0 raw 0x12 | 0x40 -> field 18; ch3 field 18: pulse every cycle
        count(10);
        chk("R8 fraction 18 every cycle ch0", cnt[0], 10);
        chk("R8 fraction 18 every cycle ch3", cnt[3], 10);

        // R7: stop ch0, quiet from the second sample on
        wr(2'd1, 32'h00000080);
        count(1);
        count(12);
        chk("R7 stopped channel quiet", cnt[0], 0);
        chk("R7 other channel unaffected", cnt[3], 12);

        // R7: clean restart after stop, fraction 35
        wr(2'd0, 32'h929292A3);
        wr(2'd2, 32'h00000080);
        count(35);
        chk("R7 restart count fraction 35", cnt[0], 18);
        wr(2'd1, 32'h00000080);
        wr(2'd2, 32'h00000080);
        count(17);
        chk("R7 second restart partial window", cnt[0], (18 * 17) / 35);

        // R8: fraction field 0 acts as 18
        wr(2'd0, 32'h92929200);
        count(15);
        chk("R8 fraction 0 clamps to 18", cnt[0], 15);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule